// File: doc/BRIEF.md
# Translating Width-Converting DMA Channel

This block is a single DMA channel that copies a stream of bytes from a source pointer to a destination pointer over one shared memory port. Each byte may be replaced by an entry from a 256-byte lookup table in memory before it is written. The channel can read the source as bytes or as 16-bit words and write the destination as bytes or as 16-bit words, so it packs or unpacks data between the two widths.

Software loads the pointers, the byte count, a mask/pattern word and a control word, then pulses `start`. The transfer ends on a count running out, on a masked byte match, or after the first destination write in single-transfer mode. A three-bit status records which conditions ended it and is held, with `done`, until the next start.

Top module: `xdc_chan`

## Requirements
- R1: After reset the channel is idle: `busy`=0, `done`=0, `stat`=0 and `mem_req`=0. No memory request is made while idle.
- R2: Bytes are written to the destination in source order. The byte image at `dst_addr` equals the processed source bytes, with source and destination addresses rising by 1 per byte access and by 2 per word access.
- R3: With control bit 13 set, each byte is replaced by the byte read at `tbl_addr` + byte value, using one byte read per byte.
- R4: The compare uses `mc[7:0]` as the pattern and `mc[15:8]` as the mask. A byte hits when every bit whose mask bit is 1 equals the pattern bit, so a mask of 0 always hits. The compare uses the byte after translation. With control bit 1 set, the hitting byte is still written, and then the transfer ends.
- R5: With control bit 0 set, the count drops by one for each byte, and the transfer ends after the byte that brings it to zero.
- R6: With control bit 14 set, two bytes form one 16-bit write at an even address, with the first byte in bits 7..0. A lone byte left when the transfer ends is written as a single byte write.
- R7: With control bit 15 set, one 16-bit read at an even address gives two bytes, bits 7..0 first. A high byte not needed when the transfer ends is dropped.
- R8: With control bit 7 set, the transfer ends after the first completed destination write, whether a byte or a word, regardless of the count.
- R9: `stat` bit 0 marks an end on the count, bit 1 an end on a match and bit 2 an end in single mode. All conditions that hold at the end are set. `done` and `stat` hold until the next `start`, which clears both.
- R10: While `mem_req` is high without `mem_gnt`, the request and its address, direction, width and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| src_addr | input | AW | Source pointer |
| dst_addr | input | AW | Destination pointer |
| tbl_addr | input | AW | Translation table base |
| count | input | CW | Byte count |
| mc | input | 16 | Mask (15..8) and pattern (7..0) |
| ctl | input | 16 | Control word |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory grant; an access completes when request and grant are both high |
| mem_we | output | 1 | 1 = write |
| mem_wide | output | 1 | 1 = 16-bit access, 0 = byte in bits 7..0 |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the granting cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished, held until next start |
| stat | output | 3 | End conditions {single, match, count} |

## Verification
A wrong pointer, packing register or count shows at the ports either as a wrong byte in the destination image or as a wrong mix of byte and word accesses. The bench sees either one once `done` rises. A count or compare error moves the end point: an extra or a missing byte shows next to the destination region, and a wrong `stat` bit shows in the cycle after the last write. A request that changes while it waits for grant is caught in the first stalled cycle.

// File: rtl/xdc_pkg.sv
package xdc_pkg;
  localparam int CB_SRCW   = 15;
  localparam int CB_DSTW   = 14;
  localparam int CB_XLT    = 13;
  localparam int CB_SINGLE = 7;
  localparam int CB_MATCH  = 1;
  localparam int CB_CNT    = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDSRC, ST_RDTBL, ST_PROC, ST_WRDST
  } st_t;

  function automatic logic byte_hit(input logic [7:0] b, input logic [15:0] mcw);
    return ((b ^ mcw[7:0]) & mcw[15:8]) == 8'h00;
  endfunction

  function automatic logic [1:0] ptr_step(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/xdc_ptr.sv
module xdc_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          wide,
  output logic [AW-1:0] q
);
  import xdc_pkg::*;
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= ld_val;
    else if (step) q <= q + AW'(ptr_step(wide));
  end
endmodule

// File: rtl/xdc_term.sv
module xdc_term #(
  parameter int CW = 16
) (
  input  logic [7:0]    bval,
  input  logic [15:0]   mcw,
  input  logic [CW-1:0] cnt,
  input  logic          en_cnt,
  input  logic          en_match,
  output logic          hit,
  output logic          stop_match,
  output logic          stop_cnt
);
  import xdc_pkg::*;
  always_comb begin
    hit        = byte_hit(bval, mcw);
    stop_match = en_match && hit;
    stop_cnt   = en_cnt && (cnt == CW'(1));
  end
endmodule

// File: rtl/xdc_pack.sv
module xdc_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load,
  input  logic [7:0] d,
  output logic [7:0] lo,
  output logic       pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo   <= 8'h00;
      pend <= 1'b0;
    end else if (load) begin
      lo   <= d;
      pend <= 1'b1;
    end else if (clr) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/xdc_chan.sv
module xdc_chan #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [AW-1:0] tbl_addr,
  input  logic [CW-1:0] count,
  input  logic [15:0]   mc,
  input  logic [15:0]   ctl,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [2:0]    stat
);
  import xdc_pkg::*;
  localparam int NPTR = 2;

  st_t           st_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   mc_q, ctl_q, wbuf_q;
  logic [AW-1:0] tbl_q;
  logic [7:0]    cur_q, hi_q;
  logic          hi_pend_q, wwide_q, stop_q, done_q;
  logic [2:0]    stat_q;

  // mode decode
  logic m_srcw, m_dstw, m_xlt, single_q, en_cnt, en_match;
  assign m_srcw   = ctl_q[CB_SRCW];
  assign m_dstw   = ctl_q[CB_DSTW];
  assign m_xlt    = ctl_q[CB_XLT];
  assign single_q = ctl_q[CB_SINGLE];
  assign en_cnt   = ctl_q[CB_CNT];
  assign en_match = ctl_q[CB_MATCH];

  // named events
  logic launch, fire, byte_evt, wr_fire, hit, stop_match, stop_cnt, stop_now, match_stop;
  assign launch     = (st_q == ST_IDLE) && start;
  assign fire       = mem_req && mem_gnt;
  assign byte_evt   = (st_q == ST_PROC);
  assign wr_fire    = (st_q == ST_WRDST) && fire;
  assign stop_now   = stop_match || stop_cnt;
  assign match_stop = byte_evt && stop_match;

  xdc_term #(.CW(CW)) u_term (
    .bval(cur_q), .mcw(mc_q), .cnt(cnt_q), .en_cnt(en_cnt), .en_match(en_match),
    .hit(hit), .stop_match(stop_match), .stop_cnt(stop_cnt)
  );

  // destination packing holder
  logic [7:0] lo_b;
  logic       lo_pend, pk_load, pk_clr;
  assign pk_load = byte_evt && m_dstw && !lo_pend && !stop_now;
  assign pk_clr  = launch || (byte_evt && lo_pend);
  xdc_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .load(pk_load), .d(cur_q),
    .lo(lo_b), .pend(lo_pend)
  );

  // source (0) and destination (1) pointers
  logic [AW-1:0] p_ld  [NPTR];
  logic [AW-1:0] p_q   [NPTR];
  logic          p_stp [NPTR];
  logic          p_wd  [NPTR];
  assign p_ld[0]  = src_addr;
  assign p_ld[1]  = dst_addr;
  assign p_stp[0] = (st_q == ST_RDSRC) && fire;
  assign p_stp[1] = wr_fire;
  assign p_wd[0]  = m_srcw;
  assign p_wd[1]  = wwide_q;

  genvar gi;
  generate
    for (gi = 0; gi < NPTR; gi++) begin : g_ptr
      xdc_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(launch), .ld_val(p_ld[gi]),
        .step(p_stp[gi]), .wide(p_wd[gi]), .q(p_q[gi])
      );
    end
  endgenerate

  // memory port
  always_comb begin
    mem_req   = (st_q == ST_RDSRC) || (st_q == ST_RDTBL) || (st_q == ST_WRDST);
    mem_we    = (st_q == ST_WRDST);
    mem_wdata = wbuf_q;
    mem_wide  = 1'b0;
    mem_addr  = p_q[1];
    case (st_q)
      ST_RDSRC: begin mem_addr = p_q[0]; mem_wide = m_srcw; end
      ST_RDTBL: mem_addr = tbl_q + AW'(cur_q);
      ST_WRDST: mem_wide = wwide_q;
      default: ;
    endcase
  end

  // state after a finished byte: next held high byte or a new source read
  st_t adv_st;
  assign adv_st = hi_pend_q ? (m_xlt ? ST_RDTBL : ST_PROC) : ST_RDSRC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; mc_q <= '0; ctl_q <= '0; tbl_q <= '0;
      cur_q <= '0; hi_q <= '0; hi_pend_q <= 1'b0; wbuf_q <= '0;
      wwide_q <= 1'b0; stop_q <= 1'b0; done_q <= 1'b0; stat_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          cnt_q <= count; mc_q <= mc; ctl_q <= ctl; tbl_q <= tbl_addr;
          hi_pend_q <= 1'b0; stop_q <= 1'b0; done_q <= 1'b0; stat_q <= '0;
          st_q <= ST_RDSRC;
        end
        ST_RDSRC: if (fire) begin
          cur_q     <= mem_rdata[7:0];
          hi_q      <= mem_rdata[15:8];
          hi_pend_q <= m_srcw;
          st_q      <= m_xlt ? ST_RDTBL : ST_PROC;
        end
        ST_RDTBL: if (fire) begin
          cur_q <= mem_rdata[7:0];
          st_q  <= ST_PROC;
        end
        ST_PROC: begin
          cnt_q     <= cnt_q - CW'(1);
          stat_q[1] <= stop_match;
          stat_q[0] <= stop_cnt;
          if (m_dstw && lo_pend) begin
            wbuf_q <= {cur_q, lo_b}; wwide_q <= 1'b1;
            stop_q <= stop_now;      st_q    <= ST_WRDST;
          end else if (!m_dstw || stop_now) begin
            wbuf_q <= {8'h00, cur_q}; wwide_q <= 1'b0;
            stop_q <= stop_now;       st_q    <= ST_WRDST;
          end else begin
            st_q <= adv_st;
            if (hi_pend_q) begin cur_q <= hi_q; hi_pend_q <= 1'b0; end
          end
        end
        ST_WRDST: if (fire) begin
          if (stop_q || single_q) begin
            st_q      <= ST_IDLE;
            done_q    <= 1'b1;
            stat_q[2] <= single_q;
          end else begin
            st_q <= adv_st;
            if (hi_pend_q) begin cur_q <= hi_q; hi_pend_q <= 1'b0; end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
  assign stat = stat_q;
endmodule

// File: rtl/xdc_chan_chk.sv
module xdc_chan_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic          mem_wide,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic          busy,
  input logic          done,
  input logic [2:0]    stat,
  input logic          byte_evt,
  input logic [CW-1:0] cnt_q,
  input logic          wr_fire,
  input logic          single_q,
  input logic          match_stop
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_match_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_stop |=> stat[1]);

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt |=> cnt_q == CW'($past(cnt_q) - CW'(1)));

  assert_word_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_wide) |-> !mem_addr[0]);

  assert_single_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && single_q) |=> (done && stat[2]));

  assert_status_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(stat)));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wide) && $stable(mem_wdata)));
endmodule

bind xdc_chan xdc_chan_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .busy(busy), .done(done), .stat(stat), .byte_evt(byte_evt), .cnt_q(cnt_q),
  .wr_fire(wr_fire), .single_q(single_q), .match_stop(match_stop)
);

// File: tb/xdc_chan_tb.sv
module xdc_chan_tb;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int SRC = 'h100;
  localparam int TBL = 'h200;
  localparam int DST = 'h300;
  localparam int NV  = 14;
  // {ctl, count, mc, n_bytes, stat}
  localparam logic [63:0] VEC [NV] = '{
    {16'h0001, 16'd5,  16'h0000, 8'd5, 8'd1},  // byte copy, count
    {16'h4001, 16'd6,  16'h0000, 8'd6, 8'd1},  // pack even
    {16'h4001, 16'd5,  16'h0000, 8'd5, 8'd1},  // pack odd, lone byte
    {16'h8001, 16'd4,  16'h0000, 8'd4, 8'd1},  // unpack
    {16'h0003, 16'd20, 16'hFF1F, 8'd5, 8'd2},  // match full mask
    {16'h2003, 16'd10, 16'hFFBD, 8'd4, 8'd2},  // match after translation
    {16'h0002, 16'd0,  16'h0F01, 8'd3, 8'd2},  // partial mask
    {16'h0002, 16'd0,  16'h0055, 8'd1, 8'd2},  // zero mask
    {16'h0081, 16'd10, 16'h0000, 8'd1, 8'd4},  // single byte
    {16'h4081, 16'd10, 16'h0000, 8'd2, 8'd4},  // single word
    {16'h0003, 16'd3,  16'hFF11, 8'd3, 8'd3},  // count and match together
    {16'hC001, 16'd4,  16'h0000, 8'd4, 8'd1},  // word to word
    {16'h4002, 16'd0,  16'hFF11, 8'd3, 8'd2},  // pack, match at odd byte
    {16'hA001, 16'd3,  16'h0000, 8'd3, 8'd1}   // unpack with translation
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0, tbl_addr = '0;
  logic [CW-1:0] count = '0;
  logic [15:0] mc = '0, ctl = '0;
  logic mem_req, mem_gnt, mem_we, mem_wide, busy, done;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [2:0] stat;

  always #(CLK_P/2) clk = ~clk;

  xdc_chan #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
    .tbl_addr(tbl_addr), .count(count), .mc(mc), .ctl(ctl), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done), .stat(stat)
  );

  // memory model with stalling grant
  logic [7:0] mem [1024];
  logic [2:0] gcnt = '0;
  logic prefill = 1'b0;
  int rd_w = 0, rd_b = 0, wr_w = 0, wr_b = 0, hold_err = 0;
  logic pend_q = 1'b0;
  logic [AW-1:0] pa_q = '0;
  logic [15:0] pd_q = '0;
  logic pw_q = 1'b0, pwd_q = 1'b0;
  logic [9:0] ma;
  assign ma = mem_addr[9:0];
  assign mem_gnt = mem_req && (gcnt != 3'd2) && (gcnt != 3'd5);
  assign mem_rdata = mem_wide ? {mem[{ma[9:1], 1'b1}], mem[{ma[9:1], 1'b0}]}
                              : {8'h00, mem[ma]};

  always @(posedge clk) begin
    gcnt <= gcnt + 3'd1;
    if (pend_q && !(mem_req && pa_q == mem_addr && pw_q == mem_we &&
                    pwd_q == mem_wide && pd_q == mem_wdata))
      hold_err <= hold_err + 1;
    pend_q <= mem_req && !mem_gnt;
    pa_q <= mem_addr; pw_q <= mem_we; pwd_q <= mem_wide; pd_q <= mem_wdata;
    if (prefill) begin
      for (int i = 0; i < 1024; i++) begin
        if (i >= SRC && i < SRC + 256)      mem[i] = 8'(i * 7 + 3);
        else if (i >= TBL && i < TBL + 256) mem[i] = 8'(i - TBL) ^ 8'hA5;
        else                                mem[i] = 8'hEE;
      end
      rd_w <= 0; rd_b <= 0; wr_w <= 0; wr_b <= 0;
    end else if (mem_req && mem_gnt) begin
      if (mem_we) begin
        if (mem_wide) begin
          mem[{ma[9:1], 1'b0}] = mem_wdata[7:0];
          mem[{ma[9:1], 1'b1}] = mem_wdata[15:8];
          wr_w <= wr_w + 1;
        end else begin
          mem[ma] = mem_wdata[7:0];
          wr_b <= wr_b + 1;
        end
      end else if (mem_wide) rd_w <= rd_w + 1;
      else                   rd_b <= rd_b + 1;
    end
  end

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int v);
    logic [15:0] c;
    int n, ex_st, ex_rw, ex_rb, ex_ww, ex_wb;
    logic [7:0] eb;
    c = VEC[v][63:48]; n = int'(VEC[v][15:8]); ex_st = int'(VEC[v][7:0]);
    @(negedge clk); prefill = 1'b1;
    @(negedge clk); prefill = 1'b0;
    src_addr = AW'(SRC); dst_addr = AW'(DST); tbl_addr = AW'(TBL);
    count = VEC[v][47:32]; mc = VEC[v][31:16]; ctl = c; start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R9: start clears status and done
    check(busy && !done && stat == 3'd0, $sformatf("R9 clear on start v%0d", v),
          int'(stat), 0);
    for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
    check(done, $sformatf("R9 done v%0d", v), int'(done), 1);
    check(int'(stat) == ex_st, $sformatf("R4 R5 R8 R9 status v%0d", v), int'(stat), ex_st);
    // R2 R3: destination image
    for (int i = 0; i < n; i++) begin
      eb = 8'(i * 7 + 3);
      if (c[13]) eb = eb ^ 8'hA5;
      check(mem[DST + i] == eb, $sformatf("R2 R3 data v%0d b%0d", v, i),
            int'(mem[DST + i]), int'(eb));
    end
    check(mem[DST + n] == 8'hEE && mem[DST + n + 1] == 8'hEE,
          $sformatf("R2 R5 guard v%0d", v), int'(mem[DST + n]), 'hEE);
    // R3 R6 R7: access mix
    ex_rw = c[15] ? (n + 1) / 2 : 0;
    ex_rb = (c[15] ? 0 : n) + (c[13] ? n : 0);
    ex_ww = c[14] ? n / 2 : 0;
    ex_wb = c[14] ? n % 2 : n;
    check(rd_w == ex_rw, $sformatf("R7 word reads v%0d", v), rd_w, ex_rw);
    check(rd_b == ex_rb, $sformatf("R3 byte reads v%0d", v), rd_b, ex_rb);
    check(wr_w == ex_ww, $sformatf("R6 word writes v%0d", v), wr_w, ex_ww);
    check(wr_b == ex_wb, $sformatf("R6 byte writes v%0d", v), wr_b, ex_wb);
  endtask

  initial begin
    bit wd;
    logic [2:0] st_snap;
    wd = 1'b0;
    fork
      begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!busy && !done && stat == 3'd0 && !mem_req, "R1 reset state",
              int'({busy, done, stat, mem_req}), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req, "R1 idle after reset", int'(mem_req), 0);
        for (int v = 0; v < NV; v++) run_vec(v);
        // R9: status held while idle
        st_snap = stat;
        repeat (8) @(negedge clk);
        check(done && stat == st_snap && !mem_req, "R9 held while idle",
              int'(stat), int'(st_snap));
        // R10: request stable during stalls
        check(hold_err == 0, "R10 request hold", hold_err, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule